// File: doc/BRIEF.md
# Programmable Watchdog Timer with Selectable Units

This block is a software watchdog for a peripheral-controller style chip. Software programs an 8-bit time-out count through a small register port and must keep rewriting it to restart the countdown. If software stops rewriting it, the count reaches zero. The block then latches a time-out flag and raises an alarm. A configuration bit selects the alarm type: a level interrupt request, or a fixed-length active-low reset pulse.

Each decrement of the count takes one second or one minute, as a configuration bit chooses. The second and minute ticks come from an internal prescaler. Its clock-cycles-per-second and seconds-per-minute ratios are parameters. Every write to the count register restarts the prescaler, so the first unit after a write is always a full one. Writing zero to the count register stops the watchdog and raises no alarm.

The register port is a plain single-cycle write strobe with a 2-bit address and combinational read data. Bus decoding belongs to the system around the block.

Top module: `wdt_unit_timer`

## Requirements
- R1: After reset, the remaining count is 0, the time-out flag is clear, `irq` is low, `sys_rst_n` is high and the configuration reads 0.
- R2: A write to address 1 loads the written value into the counter. A read of address 1 returns the remaining count, which drops by exactly one per elapsed unit.
- R3: With configuration bit 7 = 0 (seconds), a non-zero value N written at clock edge E expires at edge E + N·CYC_PER_SEC. At that edge the count reaches 0 and the flag sets.
- R4: With configuration bit 7 = 1 (minutes), the count expires at edge E + N·CYC_PER_SEC·SEC_PER_MIN and does not decrement after a single second.
- R5: Rewriting address 1 while counting restarts the countdown from the new value with a full first unit. The expiry is timed from the rewrite.
- R6: Writing 0 to address 1 stops the counter. No expiry, flag or alarm follows.
- R7: The time-out flag is read at address 2 bit 0. It stays set after the counter stops at zero. Writing 1 to address 2 bit 0 clears it. Writing 0 there has no effect.
- R8: With configuration bit 6 = 0 (interrupt routing), `irq` is high exactly while the flag is set, and `sys_rst_n` stays high.
- R9: With configuration bit 6 = 1 (reset routing), `sys_rst_n` is low for exactly RST_PULSE cycles, starting at the expiry edge, and `irq` stays low.
- R10: A read of address 0 returns configuration bits 7 and 6 as written, with bits 5..0 reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register select: 0 config, 1 count, 2 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt while flagged, when routed to interrupt |
| sys_rst_n | output | 1 | Active-low reset pulse, when routed to reset |

## Verification
The bench builds the block with CYC_PER_SEC = 3, SEC_PER_MIN = 4 and RST_PULSE = 5. This shrinks a second to three cycles and a minute to twelve. The seconds-mode sweep can then cover every count value from 1 to 255, checking the exact expiry edge and the first decrement for each value. Minute mode is run at both ends of the count range. The short reset pulse lets every cycle of its width be checked.

// File: rtl/wdt_unit_pkg.sv
package wdt_unit_pkg;
   localparam int REG_W         = 8;
   localparam int CFG_UNIT_BIT  = 7;
   localparam int CFG_ROUTE_BIT = 6;
   localparam int STS_FLAG_BIT  = 0;

   typedef enum logic [1:0] {
      SEL_CFG = 2'd0,
      SEL_VAL = 2'd1,
      SEL_STS = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic unit_min;
      logic route_rst;
   } wdt_cfg_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int CYC_PER_SEC = 1000,
   parameter int SEC_PER_MIN = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic sec_tick,
   output logic min_tick
);
   localparam int PW = (CYC_PER_SEC > 1) ? $clog2(CYC_PER_SEC) : 1;
   localparam logic [PW-1:0] P_LAST = PW'(CYC_PER_SEC - 1);

   if (CYC_PER_SEC < 2) begin : g_bad_cps
      $error("CYC_PER_SEC must be at least 2");
   end
   if (SEC_PER_MIN < 1) begin : g_bad_spm
      $error("SEC_PER_MIN must be at least 1");
   end

   logic [PW-1:0] pcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               pcnt <= '0;
      else if (restart)         pcnt <= '0;
      else if (pcnt == P_LAST)  pcnt <= '0;
      else                      pcnt <= pcnt + 1'b1;
   end

   assign sec_tick = (pcnt == P_LAST);

   if (SEC_PER_MIN == 1) begin : g_min_eq_sec
      assign min_tick = sec_tick;
   end else begin : g_min_div
      localparam int MW = $clog2(SEC_PER_MIN);
      localparam logic [MW-1:0] M_LAST = MW'(SEC_PER_MIN - 1);
      logic [MW-1:0] mcnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        mcnt <= '0;
         else if (restart)  mcnt <= '0;
         else if (sec_tick) mcnt <= (mcnt == M_LAST) ? '0 : mcnt + 1'b1;
      end

      assign min_tick = sec_tick && (mcnt == M_LAST);
   end

   // R5: a restart always leaves a full period before the next tick
   p_restart_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !sec_tick);
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   if (CNT_W < 1) begin : g_bad_w
      $error("CNT_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    count <= '0;
      else if (load)                 count <= load_val;
      else if (step && count != '0)  count <= count - 1'b1;
   end

   assign expire = step && !load && (count == CNT_W'(1));

   // R2: a load takes the written value
   p_load_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> count == $past(load_val));
   // R2: one unit removes exactly one from the count
   p_dec_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && count != '0) |=> count == $past(count) - 1'b1);
   // R6: a stopped counter stays at zero
   p_zero_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && count == '0) |=> count == '0);
endmodule

// File: rtl/wdt_alarm_route.sv
module wdt_alarm_route #(
   parameter int RST_PULSE = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic flag,
   input  logic route_rst,
   output logic irq,
   output logic sys_rst_n
);
   localparam int RW = $clog2(RST_PULSE + 1);
   localparam logic [RW-1:0] PULSE_LEN = RW'(RST_PULSE);

   if (RST_PULSE < 1) begin : g_bad_pulse
      $error("RST_PULSE must be at least 1");
   end

   logic [RW-1:0] rcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     rcnt <= '0;
      else if (expire && route_rst)   rcnt <= PULSE_LEN;
      else if (rcnt != '0)            rcnt <= rcnt - 1'b1;
   end

   assign sys_rst_n = (rcnt == '0);
   assign irq       = flag && !route_rst;

   // R9: the reset line only falls on an expiry routed to reset
   p_rst_from_expiry_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_rst_n) |-> $past(expire && route_rst));
   // R8: an interrupt rises only once the flag is up
   p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> flag);
endmodule

// File: rtl/wdt_unit_timer.sv
module wdt_unit_timer
   import wdt_unit_pkg::*;
#(
   parameter int CYC_PER_SEC = 1000000,
   parameter int SEC_PER_MIN = 60,
   parameter int RST_PULSE   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [1:0]       reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             irq,
   output logic             sys_rst_n
);
   reg_sel_e   sel;
   wdt_cfg_t   cfg_q;
   logic       flag_q;
   logic       val_load, cfg_wr, flag_clr;
   logic       sec_tick, min_tick, step, expire;
   logic [REG_W-1:0] count;

   assign sel      = reg_sel_e'(reg_addr);
   assign cfg_wr   = reg_wr && (sel == SEL_CFG);
   assign val_load = reg_wr && (sel == SEL_VAL);
   assign flag_clr = reg_wr && (sel == SEL_STS) && reg_wdata[STS_FLAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (cfg_wr) begin
         cfg_q.unit_min  <= reg_wdata[CFG_UNIT_BIT];
         cfg_q.route_rst <= reg_wdata[CFG_ROUTE_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q <= 1'b0;
      else if (expire)    flag_q <= 1'b1;
      else if (flag_clr)  flag_q <= 1'b0;
   end

   wdt_prescaler #(
      .CYC_PER_SEC(CYC_PER_SEC),
      .SEC_PER_MIN(SEC_PER_MIN)
   ) presc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (val_load),
      .sec_tick (sec_tick),
      .min_tick (min_tick)
   );

   assign step = cfg_q.unit_min ? min_tick : sec_tick;

   wdt_down_counter #(
      .CNT_W(REG_W)
   ) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (val_load),
      .load_val (reg_wdata),
      .step     (step),
      .count    (count),
      .expire   (expire)
   );

   wdt_alarm_route #(
      .RST_PULSE(RST_PULSE)
   ) alarm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .expire    (expire),
      .flag      (flag_q),
      .route_rst (cfg_q.route_rst),
      .irq       (irq),
      .sys_rst_n (sys_rst_n)
   );

   always_comb begin
      reg_rdata = '0;
      case (sel)
         SEL_CFG: begin
            reg_rdata[CFG_UNIT_BIT]  = cfg_q.unit_min;
            reg_rdata[CFG_ROUTE_BIT] = cfg_q.route_rst;
         end
         SEL_VAL: reg_rdata = count;
         SEL_STS: reg_rdata[STS_FLAG_BIT] = flag_q;
         default: reg_rdata = '0;
      endcase
   end

   // R3: an expiry always leaves the flag set
   p_expire_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> flag_q);
   // R7: the flag stays set until a clearing write
   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !flag_clr) |=> flag_q);
   // R7: the flag never sets without an expiry
   p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(expire));
endmodule

// File: tb/wdt_unit_timer_tb_top.sv
`timescale 1ns/10ps
module wdt_unit_timer_tb_top;
   localparam int C = 3;
   localparam int M = 4;
   localparam int P = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       irq, sys_rst_n;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   wdt_unit_timer #(.CYC_PER_SEC(C), .SEC_PER_MIN(M), .RST_PULSE(P)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .sys_rst_n(sys_rst_n)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      reg_addr = a;
      #0.1;
      v = int'(reg_rdata);
   endtask

   initial begin
      int v;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      rd(2'd1, v); chk(v == 0, "R1 count", v, 0);
      rd(2'd2, v); chk(v == 0, "R1 flag", v, 0);
      rd(2'd0, v); chk(v == 0, "R1 config", v, 0);
      chk(irq == 1'b0, "R1 irq", int'(irq), 0);
      chk(sys_rst_n == 1'b1, "R1 sys_rst_n", int'(sys_rst_n), 1);

      // R10 config readback
      wr(2'd0, 8'hFF);
      rd(2'd0, v); chk(v == 8'hC0, "R10 cfg all ones", v, 8'hC0);
      wr(2'd0, 8'h3F);
      rd(2'd0, v); chk(v == 0, "R10 cfg low bits", v, 0);

      // R3/R2/R8 seconds sweep over every count
      for (int n = 1; n <= 255; n++) begin
         wr(2'd1, 8'(n));
         if (n >= 2) begin
            cyc(C - 1);
            rd(2'd1, v); chk(v == n, "R2 no early step", v, n);
            cyc(1);
            rd(2'd1, v); chk(v == n - 1, "R2 first step", v, n - 1);
            cyc(n * C - 1 - C);
         end else begin
            cyc(n * C - 1);
         end
         rd(2'd1, v); chk(v == 1, "R3 count before expiry", v, 1);
         chk(irq == 1'b0, "R3 irq before expiry", int'(irq), 0);
         cyc(1);
         rd(2'd1, v); chk(v == 0, "R3 count at expiry", v, 0);
         chk(irq == 1'b1, "R8 irq at expiry", int'(irq), 1);
         chk(sys_rst_n == 1'b1, "R8 no reset pulse", int'(sys_rst_n), 1);
         wr(2'd2, 8'h01);
      end

      // R7 sticky flag and write-one-to-clear
      wr(2'd1, 8'd2);
      cyc(2 * C + 20);
      rd(2'd2, v); chk(v == 1, "R7 flag held", v, 1);
      rd(2'd1, v); chk(v == 0, "R7 count stopped", v, 0);
      wr(2'd2, 8'hFE);
      rd(2'd2, v); chk(v == 1, "R7 write 0 ignored", v, 1);
      chk(irq == 1'b1, "R8 irq follows flag", int'(irq), 1);
      wr(2'd2, 8'h01);
      rd(2'd2, v); chk(v == 0, "R7 cleared", v, 0);
      chk(irq == 1'b0, "R8 irq drops", int'(irq), 0);

      // R5 rewrite restarts mid-count
      wr(2'd1, 8'd3);
      cyc(2 * C + 1);
      wr(2'd1, 8'd3);
      cyc(C - 1);
      rd(2'd1, v); chk(v == 3, "R5 full first unit", v, 3);
      cyc(2 * C);
      chk(irq == 1'b0, "R5 no early expiry", int'(irq), 0);
      cyc(1);
      chk(irq == 1'b1, "R5 expiry from rewrite", int'(irq), 1);
      wr(2'd2, 8'h01);

      // R6 write zero stops
      wr(2'd1, 8'd5);
      cyc(4);
      wr(2'd1, 8'd0);
      cyc(10 * C);
      rd(2'd1, v); chk(v == 0, "R6 stopped count", v, 0);
      rd(2'd2, v); chk(v == 0, "R6 no flag", v, 0);
      chk(irq == 1'b0, "R6 no irq", int'(irq), 0);

      // R4 minute mode
      wr(2'd0, 8'h80);
      for (int k = 0; k < 4; k++) begin
         int n;
         n = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 7 : 255;
         wr(2'd1, 8'(n));
         cyc(C);
         rd(2'd1, v); chk(v == n, "R4 no step per second", v, n);
         if (n >= 2) begin
            cyc(C * M - C);
            rd(2'd1, v); chk(v == n - 1, "R4 step per minute", v, n - 1);
            cyc(n * C * M - 1 - C * M);
         end else begin
            cyc(C * M - 1 - C);
         end
         chk(irq == 1'b0, "R4 irq before expiry", int'(irq), 0);
         cyc(1);
         chk(irq == 1'b1, "R4 irq at expiry", int'(irq), 1);
         wr(2'd2, 8'h01);
      end

      // R9 reset routing
      wr(2'd0, 8'h40);
      wr(2'd1, 8'd2);
      cyc(2 * C - 1);
      chk(sys_rst_n == 1'b1, "R9 high before expiry", int'(sys_rst_n), 1);
      for (int i = 0; i < P; i++) begin
         cyc(1);
         chk(sys_rst_n == 1'b0, "R9 pulse low", int'(sys_rst_n), 0);
         chk(irq == 1'b0, "R9 irq silent", int'(irq), 0);
      end
      cyc(1);
      chk(sys_rst_n == 1'b1, "R9 pulse end", int'(sys_rst_n), 1);
      rd(2'd2, v); chk(v == 1, "R9 flag set", v, 1);
      cyc(20);
      chk(sys_rst_n == 1'b1, "R9 single pulse", int'(sys_rst_n), 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule